// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block is the control logic that sits between a clock generator's PLL and its output drivers. It decides, cycle by cycle, whether each differential output pair runs or is parked low, and whether the single-ended reference output is high impedance, held low or running. The inputs it weighs are a power-good / power-down pin, one active-low enable pin per differential pair, the matching enable bits from a configuration register, a reference enable bit, a keep-alive bit that lets the reference run through power-down, and a PLL lock flag.

The power-good pin and the enable pins are asynchronous. They pass through a synchronizer in the output clock domain. All gate controls are registered on the falling clock edge, so an output is released or parked only while the clock is low and no runt pulse can occur. The first high level of power-good after reset starts the device and captures the strap inputs. The same event ends the reference's high-impedance state for good. Later low levels of power-good power the outputs down, and later high levels bring them back. The register bits and the lock flag are synchronous to `clk`.

Top module: `clk_gate_seq`

## Requirements
- R1: The first power-good high level seen after reset copies `strapIn` into `strapLatched`. No later power-good cycle changes `strapLatched`, even when `strapIn` has changed.
- R2: While the synchronized power-good is low, every bit of `difRun` is 0 (pair parked low/low).
- R3: `difRun[i]` is 1 only when power-good is high, `pllLocked` is 1, `regDifEn[i]` is 1 and `oeN[i]` is 0. Otherwise it is 0.
- R4: When `pllLocked` falls, all pairs stop within one clock, whatever the enables are.
- R5: `refMode` encodes 2'b00 = high-Z, 2'b01 = driven low, 2'b10 = running. It stays 2'b00 from reset until power-good is first seen high, whatever the other inputs are.
- R6: After the first power-good, the reference runs while power-good is high. While power-good is low it is driven low, except that it keeps running when `regWol` is 1.
- R7: After the first power-good, `regRefEn` = 0 holds the reference low in every state.
- R8: A change on `oeN[i]` or `pwrGood` reaches the outputs no sooner than one clock and no later than three clocks after the change.
- R9: `difRun` and `refMode` change only while `clk` is low.
- R10: During reset, `difRun` is 0, `refMode` is high-Z and `strapLatched` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock that times all gating |
| rstN | input | 1 | Global asynchronous reset, active low |
| pwrGood | input | 1 | Asynchronous power-good; low requests power-down |
| oeN | input | NUM_DIF | Asynchronous active-low enable pin per differential pair |
| regDifEn | input | NUM_DIF | Register enable bit per pair (1 = may run) |
| regRefEn | input | 1 | Register enable for the reference output |
| regWol | input | 1 | Keep the reference running during power-down |
| pllLocked | input | 1 | PLL lock indication, synchronous to clk |
| strapIn | input | STRAP_W | Strap levels to be captured at start-up |
| difRun | output | NUM_DIF | 1 = pair runs, 0 = pair parked low/low |
| refMode | output | 2 | Reference drive: 00 high-Z, 01 low, 10 running |
| strapLatched | output | STRAP_W | Straps captured at the first power-good |

## Verification
At the first power-good level, three things happen in one cycle: the straps are captured, the reference leaves high-Z, and the differential pairs may start. The bench brings power-good up for the first time with pins, lock and register bits already set to many combinations. It then checks the captured strap, the reference mode and the pair gates against its own model. A second sweep repeats every combination once the sticky flag is set, with a changed strap value on the input, to show that capture never happens again. Pin and power-good latency is judged by sampling one clock and three clocks after each change. A monitor checks that no gate moves while the clock is high.

// File: rtl/clk_gate_seq_pkg.sv
package clk_gate_seq_pkg;

  typedef enum logic [1:0] {
    REF_HIZ = 2'b00,
    REF_LOW = 2'b01,
    REF_RUN = 2'b10
  } refMode_e;

  typedef struct packed {
    logic     captureStrap;
    refMode_e refWant;
  } gateStrobe_t;

endpackage

// File: rtl/clk_gate_seq_ctrl.sv
module clk_gate_seq_ctrl
  import clk_gate_seq_pkg::*;
#(
  parameter int NUM_DIF     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic [NUM_DIF-1:0] oeN,
  input  logic [NUM_DIF-1:0] regDifEn,
  input  logic               regRefEn,
  input  logic               regWol,
  input  logic               pllLocked,
  output gateStrobe_t        strobe,
  output logic [NUM_DIF-1:0] difWant
);

  localparam int SW = NUM_DIF + 1;
  localparam logic [SW-1:0] SYNC_RST = {{NUM_DIF{1'b1}}, 1'b0};

  logic [SW-1:0] syncPipe [SYNC_STAGES];

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[g] <= SYNC_RST;
          else       syncPipe[g] <= {oeN, pwrGood};
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[g] <= SYNC_RST;
          else       syncPipe[g] <= syncPipe[g-1];
        end
      end
    end
  endgenerate

  logic               pgSync;
  logic [NUM_DIF-1:0] oeNSync;
  logic               seenPg;
  logic               seenNow;

  assign pgSync  = syncPipe[SYNC_STAGES-1][0];
  assign oeNSync = syncPipe[SYNC_STAGES-1][SW-1:1];
  assign seenNow = seenPg | pgSync;

  // sticky start-up flag, cleared only by the global reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       seenPg <= 1'b0;
    else if (pgSync) seenPg <= 1'b1;
  end

  always_comb begin
    strobe.captureStrap = pgSync & ~seenPg;
    difWant = {NUM_DIF{pgSync & pllLocked}} & regDifEn & ~oeNSync;
    if (!seenNow)               strobe.refWant = REF_HIZ;
    else if (!regRefEn)         strobe.refWant = REF_LOW;
    else if (pgSync || regWol)  strobe.refWant = REF_RUN;
    else                        strobe.refWant = REF_LOW;
  end

  // R1: the start-up flag never falls once set
  a_r1_seen_sticky: assert property (@(posedge clk) disable iff (!rstN)
    seenPg |=> seenPg);

  // R1: capture is a single-cycle event
  a_r1_capture_once: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureStrap |=> !strobe.captureStrap);

  // R4: no pair is requested while the PLL is unlocked
  a_r4_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !pllLocked |-> (difWant == '0));

endmodule

// File: rtl/clk_gate_seq_dp.sv
module clk_gate_seq_dp
  import clk_gate_seq_pkg::*;
#(
  parameter int NUM_DIF = 2,
  parameter int STRAP_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobe_t        strobe,
  input  logic [NUM_DIF-1:0] difWant,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [NUM_DIF-1:0] difRun,
  output logic [1:0]         refMode,
  output logic [STRAP_W-1:0] strapLatched
);

  logic [NUM_DIF-1:0] difRunQ;
  refMode_e           refModeQ;
  logic [STRAP_W-1:0] strapQ;

  // gate registers update on the falling edge: changes land in the low phase
  generate
    for (genvar i = 0; i < NUM_DIF; i++) begin : gGate
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) difRunQ[i] <= 1'b0;
        else       difRunQ[i] <= difWant[i];
      end
    end
  endgenerate

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) refModeQ <= REF_HIZ;
    else       refModeQ <= strobe.refWant;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    strapQ <= '0;
    else if (strobe.captureStrap) strapQ <= strapIn;
  end

  assign difRun       = difRunQ;
  assign refMode      = refModeQ;
  assign strapLatched = strapQ;

  // R9: gates move only during the low phase of the clock
  always @(difRunQ or refModeQ) begin
    if (rstN) begin
      a_r9_low_phase: assert (!clk) else $error("gate changed with clk high");
    end
  end

  // R1: straps hold except on the capture strobe
  a_r1_strap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureStrap |=> $stable(strapQ));

  // R5: once out of high-Z the reference never returns to it
  a_r5_no_hiz_return: assert property (@(posedge clk) disable iff (!rstN)
    (refModeQ != REF_HIZ) |=> (refModeQ != REF_HIZ));

endmodule

// File: rtl/clk_gate_seq.sv
module clk_gate_seq
  import clk_gate_seq_pkg::*;
#(
  parameter int NUM_DIF     = 2,
  parameter int STRAP_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pwrGood,
  input  logic [NUM_DIF-1:0] oeN,
  input  logic [NUM_DIF-1:0] regDifEn,
  input  logic               regRefEn,
  input  logic               regWol,
  input  logic               pllLocked,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [NUM_DIF-1:0] difRun,
  output logic [1:0]         refMode,
  output logic [STRAP_W-1:0] strapLatched
);

  gateStrobe_t        strobe;
  logic [NUM_DIF-1:0] difWant;

  clk_gate_seq_ctrl #(
    .NUM_DIF(NUM_DIF), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .oeN(oeN),
    .regDifEn(regDifEn), .regRefEn(regRefEn), .regWol(regWol),
    .pllLocked(pllLocked), .strobe(strobe), .difWant(difWant)
  );

  clk_gate_seq_dp #(
    .NUM_DIF(NUM_DIF), .STRAP_W(STRAP_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .difWant(difWant),
    .strapIn(strapIn), .difRun(difRun), .refMode(refMode),
    .strapLatched(strapLatched)
  );

endmodule

// File: tb/test_clk_gate_seq.sv
module test_clk_gate_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGood = 1'b0;
  logic [1:0] oeN = 2'b11;
  logic [1:0] regDifEn = 2'b11;
  logic       regRefEn = 1'b1;
  logic       regWol = 1'b0;
  logic       pllLocked = 1'b0;
  logic [1:0] strapIn = 2'b11;
  logic [1:0] difRun;
  logic [1:0] refMode;
  logic [1:0] strapLatched;

  int nChecks = 0;
  int nFails  = 0;
  int highPhaseMoves = 0;
  bit seen = 1'b0;

  always #4 clk = ~clk;

  clk_gate_seq i_clk_gate_seq (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .oeN(oeN),
    .regDifEn(regDifEn), .regRefEn(regRefEn), .regWol(regWol),
    .pllLocked(pllLocked), .strapIn(strapIn), .difRun(difRun),
    .refMode(refMode), .strapLatched(strapLatched)
  );

  // R9 monitor: a gate moving while clk is high is a miscompare
  always @(difRun or refMode) if (rstN && clk) highPhaseMoves++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic toMid();
    @(posedge clk); #2;
  endtask

  task automatic checkModel(input string tag);
    logic [1:0] expDif;
    logic [1:0] expRef;
    expDif = (pwrGood && pllLocked) ? (regDifEn & ~oeN) : 2'b00;
    if (!seen)                     expRef = 2'b00;
    else if (!regRefEn)            expRef = 2'b01;
    else if (pwrGood || regWol)    expRef = 2'b10;
    else                           expRef = 2'b01;
    check({tag, " R2/R3/R4 difRun"}, {6'd0, difRun}, {6'd0, expDif});
    check({tag, " R5/R6/R7 refMode"}, {6'd0, refMode}, {6'd0, expRef});
  endtask

  task automatic applyVec(input logic [7:0] v, input string tag);
    pllLocked = v[0];
    regDifEn  = v[2:1];
    oeN       = v[4:3];
    regRefEn  = v[5];
    regWol    = v[6];
    pwrGood   = v[7];
    repeat (3) toMid();
    if (pwrGood) seen = 1'b1;
    checkModel(tag);
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R10: reset state
    #1;
    check("R10 difRun", {6'd0, difRun}, 8'h00);
    check("R10 refMode", {6'd0, refMode}, 8'h00);
    check("R10 strap", {6'd0, strapLatched}, 8'h00);
    repeat (2) toMid();
    rstN = 1'b1;
    repeat (2) toMid();

    // sweep 1: first 128 vectors have power-good low (R5), then first power-good
    for (int v = 0; v < 256; v++) applyVec(v[7:0], "sweep1");
    check("R1 strap captured", {6'd0, strapLatched}, 8'h03);

    // sweep 2: change straps, repeat everything (no recapture)
    strapIn = 2'b01;
    for (int v = 0; v < 256; v++) applyVec(8'(255 - v), "sweep2");
    for (int v = 0; v < 256; v++) applyVec(v[7:0], "sweep3");
    check("R1 strap held", {6'd0, strapLatched}, 8'h03);

    // R8 latency on an enable pin
    applyVec(8'b1010_0111, "R8 setup");
    check("R8 both running", {6'd0, difRun}, 8'h03);
    oeN[0] = 1'b1;
    #8  check("R8 pin stop not early", {6'd0, difRun}, 8'h03);
    #16 check("R8 pin stop by 3 clocks", {6'd0, difRun}, 8'h02);
    oeN[0] = 1'b0;
    #8  check("R8 pin start not early", {6'd0, difRun}, 8'h02);
    #16 check("R8 pin start by 3 clocks", {6'd0, difRun}, 8'h03);

    // R8 latency on power-good, R2 and R6 in power-down
    pwrGood = 1'b0;
    #8  check("R8 pg stop not early", {6'd0, difRun}, 8'h03);
    #16 check("R2 pg low parks pairs", {6'd0, difRun}, 8'h00);
    check("R6 ref low in power-down", {6'd0, refMode}, 8'h01);
    regWol = 1'b1;
    #8  check("R6 ref runs with keep-alive", {6'd0, refMode}, 8'h02);
    pwrGood = 1'b1;
    #8  check("R8 pg start not early", {6'd0, difRun}, 8'h00);
    #16 check("R8 pg start by 3 clocks", {6'd0, difRun}, 8'h03);

    // R4: lock loss stops pairs within one clock
    pllLocked = 1'b0;
    #8  check("R4 lock loss", {6'd0, difRun}, 8'h00);
    pllLocked = 1'b1;
    #8  check("R4 lock regained", {6'd0, difRun}, 8'h03);

    // R7: reference disable
    regRefEn = 1'b0;
    #8  check("R7 ref held low", {6'd0, refMode}, 8'h01);

    // R9: no gate moved while clk was high
    check("R9 high-phase moves", 8'(highPhaseMoves), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule